// File: doc/BRIEF.md
# Prioritized Banked Interrupt Controller

This block merges 96 level-sensitive interrupt requests into two processor lines: a normal line and a fast line. The sources are grouped in three banks of 32. Each bank has a view of the raw inputs, a mask with separate one-bits-set and one-bits-clear write ports, and software-forced request set and clear ports. It also has masked pending views, one for each output line. Each source has a line register that gives its priority and the output it is routed to.

For each output, a combinational sorter picks the eligible source with the best priority. When the output is idle, the controller latches that source's number into the output's active register and raises the line. The number then stays frozen until software writes the acknowledge bit. That write releases both lines, and arbitration runs again on the next clock. A priority threshold can hold back low-urgency sources. A software-started reset returns every register to its initial value and reports when it has finished.

Register access is a single-cycle port: writes are taken on the clock edge when `wrEn` is high, and `rdData` is a combinational function of `addr`. Word addresses: 0x00 config, 0x01 status, 0x02 normal active number, 0x03 fast active number, 0x04 control, 0x05 threshold. Bank b occupies 0x10+8b .. 0x17+8b. The line register of source n is at 0x40+n. Write-only locations read as zero.

Top module: `intc_top`

## Requirements
- R1: Source n is bit n%32 of bank n/32; the bank raw view at offset 0 of the bank window shows `srcIn` for that bank with no masking, and software-forced requests do not appear in it.
- R2: The bank mask (offset 1, 1 = masked) is all ones after reset; writing to offset 3 sets the mask bits that are 1 in the data, writing to offset 2 clears them, and zero data bits leave the mask unchanged.
- R3: Writing ones to offset 4 forces those sources to request and writing ones to offset 5 removes the forced request; the pending views at offset 6 (normal line) and offset 7 (fast line) show (input OR forced) AND NOT mask for the sources routed to that line.
- R4: The line register at 0x40+n stores the priority in bits [7:2] and the route in bit 0 (0 = normal line, 1 = fast line); it reads back in that layout with the other bits zero, and all line registers are zero after reset.
- R5: Among eligible sources, the smallest priority value wins, and among equal priorities the lowest source number wins.
- R6: When its line is idle and an eligible source exists, an output latches the winner's number into its active register (bits [6:0] at 0x02 or 0x03) and asserts its line one clock after the source became eligible. The number and the line then hold until an acknowledge.
- R7: Writing 1 to bit 0 at 0x04 drops both lines on the next clock and lets a new winner be latched on the clock after that. The active numbers keep their old values when nothing is eligible.
- R8: The 8-bit threshold at 0x05 resets to 0xFF, which disables filtering. Any other value lets a source be delivered only if its priority is numerically below the threshold. The pending views ignore the threshold.
- R9: Writing 1 to bit 1 at 0x00 starts a soft reset that forces all state to reset values and ignores writes for 4 cycles; status bit 0 at 0x01 reads 0 during that time and 1 otherwise, and both lines stay low throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | 96 | Level-sensitive interrupt requests |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| irqOut | output | 1 | Normal interrupt line |
| fiqOut | output | 1 | Fast interrupt line |

## Verification
A corrupted mask or forced-request bit appears in the bank pending view on the next read. It also changes which number is latched one clock later. A wrong hold flag shows as an active number that moves without an acknowledge, or as a line that stays low after an acknowledge although a source is eligible. Both are visible within two clocks of the triggering write. Errors in the sorter's tie-break or in the threshold comparison show only when two sources of different or equal priority are eligible together, so the bench builds exactly those pairs.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int SRC_COUNT  = 96;
  localparam int BANK_WIDTH = 32;
  localparam int BANK_COUNT = SRC_COUNT / BANK_WIDTH;
  localparam int BANK_SEL_W = $clog2(BANK_COUNT);
  localparam int SRC_SEL_W  = $clog2(SRC_COUNT);
  localparam int NUM_W      = 7;
  localparam int PRIO_W     = 6;
  localparam int THR_W      = 8;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int BANK_STRIDE_SH = 3;

  localparam logic [ADDR_W-1:0] A_CFG      = 8'h00;
  localparam logic [ADDR_W-1:0] A_STAT     = 8'h01;
  localparam logic [ADDR_W-1:0] A_ACT_IRQ  = 8'h02;
  localparam logic [ADDR_W-1:0] A_ACT_FIQ  = 8'h03;
  localparam logic [ADDR_W-1:0] A_CTRL     = 8'h04;
  localparam logic [ADDR_W-1:0] A_THR      = 8'h05;
  localparam logic [ADDR_W-1:0] A_BANK_LO  = 8'h10;
  localparam logic [ADDR_W-1:0] A_BANK_HI  = A_BANK_LO + ADDR_W'(BANK_COUNT << BANK_STRIDE_SH);
  localparam logic [ADDR_W-1:0] A_LINE_LO  = 8'h40;
  localparam logic [ADDR_W-1:0] A_LINE_HI  = A_LINE_LO + ADDR_W'(SRC_COUNT);

  localparam logic [2:0] K_RAW   = 3'd0;
  localparam logic [2:0] K_MASK  = 3'd1;
  localparam logic [2:0] K_MCLR  = 3'd2;
  localparam logic [2:0] K_MSET  = 3'd3;
  localparam logic [2:0] K_SWSET = 3'd4;
  localparam logic [2:0] K_SWCLR = 3'd5;
  localparam logic [2:0] K_PIRQ  = 3'd6;
  localparam logic [2:0] K_PFIQ  = 3'd7;

  typedef struct packed {
    logic                  maskSet;
    logic                  maskClr;
    logic                  swSet;
    logic                  swClr;
    logic                  lineWr;
    logic                  thrWr;
    logic                  ack;
    logic                  hold;
    logic                  inBank;
    logic                  inLine;
    logic [2:0]            kind;
    logic [BANK_SEL_W-1:0] bank;
    logic [SRC_SEL_W-1:0]  line;
  } strobe_t;
endpackage

// File: rtl/intc_sorter.sv
module intc_sorter #(
  parameter int N  = 96,
  parameter int PW = 6,
  parameter int IW = 7
) (
  input  logic [N-1:0]    elig,
  input  logic [N*PW-1:0] prio,
  output logic            found,
  output logic [IW-1:0]   idx
);
  logic [PW-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int n = 0; n < N; n++) begin
      if (elig[n] && (!found || prio[n*PW +: PW] < best)) begin
        found = 1'b1;
        best  = prio[n*PW +: PW];
        idx   = IW'(n);
      end
    end
  end
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        ctlBits,
  output strobe_t           strb,
  output logic              resetDone
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0]  cnt;
  logic              busy;
  logic              softReq;
  logic              live;
  logic [ADDR_W-1:0] bankOff;
  logic [ADDR_W-1:0] lineOff;

  assign busy    = (cnt != '0);
  assign softReq = wrEn && !busy && (addr == A_CFG) && ctlBits[1];
  assign live    = wrEn && !busy;
  assign bankOff = addr - A_BANK_LO;
  assign lineOff = addr - A_LINE_LO;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (softReq) cnt <= CNT_W'(RST_CYCLES);
    else if (busy)    cnt <= cnt - 1'b1;
  end

  assign resetDone = !busy;

  always_comb begin
    strb        = '0;
    strb.inBank = (addr >= A_BANK_LO) && (addr < A_BANK_HI);
    strb.inLine = (addr >= A_LINE_LO) && (addr < A_LINE_HI);
    strb.kind   = bankOff[2:0];
    strb.bank   = bankOff[BANK_STRIDE_SH +: BANK_SEL_W];
    strb.line   = lineOff[SRC_SEL_W-1:0];
    strb.hold   = busy || softReq;
    if (live) begin
      strb.maskSet = strb.inBank && (strb.kind == K_MSET);
      strb.maskClr = strb.inBank && (strb.kind == K_MCLR);
      strb.swSet   = strb.inBank && (strb.kind == K_SWSET);
      strb.swClr   = strb.inBank && (strb.kind == K_SWCLR);
      strb.lineWr  = strb.inLine;
      strb.thrWr   = (addr == A_THR);
      strb.ack     = (addr == A_CTRL) && ctlBits[0];
    end
  end
endmodule

// File: rtl/intc_dp.sv
module intc_dp
  import intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [SRC_COUNT-1:0] srcIn,
  input  logic                 resetDone,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut,
  output logic                 fiqOut,
  output logic [NUM_W-1:0]     actIrq,
  output logic [NUM_W-1:0]     actFiq
);
  logic [SRC_COUNT-1:0]        maskR;
  logic [SRC_COUNT-1:0]        swR;
  logic [SRC_COUNT-1:0]        routeR;
  logic [PRIO_W-1:0]           prioR [SRC_COUNT];
  logic [THR_W-1:0]            thrR;

  logic [SRC_COUNT-1:0]        pendAll;
  logic [SRC_COUNT-1:0]        thrOk;
  logic [SRC_COUNT*PRIO_W-1:0] prioFlat;
  logic [SRC_COUNT-1:0]        eligCh [2];
  logic                        heldCh [2];
  logic [NUM_W-1:0]            actCh  [2];
  logic [BANK_WIDTH-1:0]       bankData;
  int                          base;

  assign base = int'(strb.bank) * BANK_WIDTH;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskR  <= '1;
      swR    <= '0;
      routeR <= '0;
      thrR   <= '1;
      for (int n = 0; n < SRC_COUNT; n++) prioR[n] <= '0;
    end else if (strb.hold) begin
      maskR  <= '1;
      swR    <= '0;
      routeR <= '0;
      thrR   <= '1;
      for (int n = 0; n < SRC_COUNT; n++) prioR[n] <= '0;
    end else begin
      if (strb.maskSet) maskR[base +: BANK_WIDTH] <= maskR[base +: BANK_WIDTH] | wrData[BANK_WIDTH-1:0];
      if (strb.maskClr) maskR[base +: BANK_WIDTH] <= maskR[base +: BANK_WIDTH] & ~wrData[BANK_WIDTH-1:0];
      if (strb.swSet)   swR[base +: BANK_WIDTH]   <= swR[base +: BANK_WIDTH] | wrData[BANK_WIDTH-1:0];
      if (strb.swClr)   swR[base +: BANK_WIDTH]   <= swR[base +: BANK_WIDTH] & ~wrData[BANK_WIDTH-1:0];
      if (strb.lineWr) begin
        prioR[strb.line]  <= wrData[PRIO_W+1:2];
        routeR[strb.line] <= wrData[0];
      end
      if (strb.thrWr) thrR <= wrData[THR_W-1:0];
    end
  end

  assign pendAll = (srcIn | swR) & ~maskR;

  for (genvar n = 0; n < SRC_COUNT; n++) begin : g_src
    assign thrOk[n] = (thrR == '1) || (THR_W'(prioR[n]) < thrR);
    assign prioFlat[n*PRIO_W +: PRIO_W] = prioR[n];
  end

  assign eligCh[0] = pendAll & ~routeR & thrOk;
  assign eligCh[1] = pendAll &  routeR & thrOk;

  for (genvar ch = 0; ch < 2; ch++) begin : g_out
    logic             found;
    logic [NUM_W-1:0] win;
    logic             held;
    logic [NUM_W-1:0] act;

    intc_sorter #(.N(SRC_COUNT), .PW(PRIO_W), .IW(NUM_W)) u_sort (
      .elig  (eligCh[ch]),
      .prio  (prioFlat),
      .found (found),
      .idx   (win)
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        held <= 1'b0;
        act  <= '0;
      end else if (strb.hold) begin
        held <= 1'b0;
        act  <= '0;
      end else if (strb.ack) begin
        held <= 1'b0;
      end else if (!held && found) begin
        held <= 1'b1;
        act  <= win;
      end
    end

    assign heldCh[ch] = held;
    assign actCh[ch]  = act;
  end

  assign irqOut = heldCh[0];
  assign fiqOut = heldCh[1];
  assign actIrq = actCh[0];
  assign actFiq = actCh[1];

  always_comb begin
    case (strb.kind)
      K_RAW:   bankData = srcIn[base +: BANK_WIDTH];
      K_MASK:  bankData = maskR[base +: BANK_WIDTH];
      K_PIRQ:  bankData = pendAll[base +: BANK_WIDTH] & ~routeR[base +: BANK_WIDTH];
      K_PFIQ:  bankData = pendAll[base +: BANK_WIDTH] &  routeR[base +: BANK_WIDTH];
      default: bankData = '0;
    endcase
  end

  always_comb begin
    rdData = '0;
    if (strb.inBank) begin
      rdData[BANK_WIDTH-1:0] = bankData;
    end else if (strb.inLine) begin
      rdData[PRIO_W+1:2] = prioR[strb.line];
      rdData[0]          = routeR[strb.line];
    end else begin
      case (addr)
        A_STAT:    rdData[0]         = resetDone;
        A_ACT_IRQ: rdData[NUM_W-1:0] = actIrq;
        A_ACT_FIQ: rdData[NUM_W-1:0] = actFiq;
        A_THR:     rdData[THR_W-1:0] = thrR;
        default:   rdData            = '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] srcIn,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut,
  output logic                 fiqOut
);
  strobe_t          strb;
  logic             resetDone;
  logic [1:0]       ctlBits;
  logic [NUM_W-1:0] actIrq;
  logic [NUM_W-1:0] actFiq;

  assign ctlBits = wrData[1:0];

  intc_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .addr      (addr),
    .ctlBits   (ctlBits),
    .strb      (strb),
    .resetDone (resetDone)
  );

  intc_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addr      (addr),
    .wrData    (wrData),
    .srcIn     (srcIn),
    .resetDone (resetDone),
    .rdData    (rdData),
    .irqOut    (irqOut),
    .fiqOut    (fiqOut),
    .actIrq    (actIrq),
    .actFiq    (actFiq)
  );
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        ctlBits,
  input logic              irqOut,
  input logic              fiqOut,
  input logic [NUM_W-1:0]  actIrq,
  input logic [NUM_W-1:0]  actFiq,
  input logic              resetDone
);
  logic ackW;
  logic softW;

  assign ackW  = wrEn && resetDone && (addr == A_CTRL) && ctlBits[0];
  assign softW = wrEn && resetDone && (addr == A_CFG) && ctlBits[1];

  p_irq_num_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut && !softW |=> $stable(actIrq));

  p_fiq_num_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut && !softW |=> $stable(actFiq));

  p_line_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut && !ackW && !softW |=> irqOut);

  p_ack_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    ackW |=> !irqOut && !fiqOut);

  p_quiet_in_reset_r9: assert property (@(posedge clk) disable iff (!rstN)
    !resetDone |-> !irqOut && !fiqOut);

  p_num_in_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut |-> actIrq < NUM_W'(SRC_COUNT)) and (fiqOut |-> actFiq < NUM_W'(SRC_COUNT)));
endmodule

bind intc_top intc_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .ctlBits   (ctlBits),
  .irqOut    (irqOut),
  .fiqOut    (fiqOut),
  .actIrq    (actIrq),
  .actFiq    (actFiq),
  .resetDone (resetDone)
);

// File: tb/intc_top_tb.sv
module intc_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [95:0] srcIn = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;
  logic        fiqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit          pins;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];

  always #2.5 clk = ~clk;

  intc_top u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .irqOut (irqOut),
    .fiqOut (fiqOut)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.pins = 1'b0; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic pinChk(input logic [1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.pins = 1'b1; it.exp = {30'b0, e}; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: compares the queued expectation against the ports
  always begin
    @(negedge clk);
    #1;
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sbq.pop_front();
      act = it.pins ? {30'b0, fiqOut, irqOut} : rdData;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    rdChk(8'h11, 32'hFFFF_FFFF, "R2 reset mask bank0");
    rdChk(8'h19, 32'hFFFF_FFFF, "R2 reset mask bank1");
    rdChk(8'h21, 32'hFFFF_FFFF, "R2 reset mask bank2");
    rdChk(8'h01, 32'h1, "R9 status after reset");
    rdChk(8'h05, 32'hFF, "R8 threshold reset");
    rdChk(8'h9F, 32'h0, "R4 line reset");
    pinChk(2'b00, "R6 lines idle after reset");

    // raw view
    srcIn[37] = 1'b1;
    srcIn[95] = 1'b1;
    rdChk(8'h18, 32'h0000_0020, "R1 raw bank1");
    rdChk(8'h20, 32'h8000_0000, "R1 raw bank2");
    rdChk(8'h1E, 32'h0, "R3 masked source not pending");
    pinChk(2'b00, "R2 masked source silent");

    // mask ports
    wr(8'h1B, 32'h0);
    rdChk(8'h19, 32'hFFFF_FFFF, "R2 zero set bits no effect");
    wr(8'h1A, 32'h0000_0020);
    rdChk(8'h19, 32'hFFFF_FFDF, "R2 clear port unmasks");
    rdChk(8'h1E, 32'h0000_0020, "R3 pending irq bank1");
    pinChk(2'b01, "R6 irq asserted");
    rdChk(8'h02, 32'd37, "R6 active number 37");

    // frozen until acknowledge
    srcIn[33] = 1'b1;
    wr(8'h1A, 32'h0000_0002);
    rdChk(8'h02, 32'd37, "R6 number frozen");
    pinChk(2'b01, "R6 line held");
    wr(8'h04, 32'h1);
    rdChk(8'h02, 32'd33, "R5 equal priority lower number");

    // priorities
    wr(8'h61, 32'h14);
    wr(8'h65, 32'h08);
    rdChk(8'h61, 32'h14, "R4 line readback");
    wr(8'h04, 32'h1);
    rdChk(8'h02, 32'd37, "R5 lower value wins");

    // threshold
    wr(8'h05, 32'h2);
    wr(8'h04, 32'h1);
    pinChk(2'b00, "R8 threshold blocks / R7 ack drops");
    rdChk(8'h02, 32'd37, "R7 number kept when idle");
    rdChk(8'h1E, 32'h0000_0022, "R8 pending ignores threshold");
    wr(8'h05, 32'h3);
    pinChk(2'b01, "R8 below threshold delivered");
    rdChk(8'h02, 32'd37, "R8 delivered number");

    // fast route
    wr(8'h9F, 32'h01);
    wr(8'h22, 32'h8000_0000);
    pinChk(2'b11, "R4 fast route asserts fiq");
    rdChk(8'h03, 32'd95, "R4 fiq active number");
    rdChk(8'h27, 32'h8000_0000, "R3 pending fiq bank2");
    rdChk(8'h26, 32'h0, "R3 pending irq bank2 empty");

    // software-forced request
    wr(8'h14, 32'h0000_0400);
    wr(8'h12, 32'h0000_0400);
    rdChk(8'h10, 32'h0, "R1 raw excludes forced");
    rdChk(8'h16, 32'h0000_0400, "R3 forced pending");
    wr(8'h04, 32'h1);
    rdChk(8'h02, 32'd10, "R3 forced source wins");
    rdChk(8'h03, 32'd95, "R7 fiq re-latched");
    wr(8'h15, 32'h0000_0400);
    rdChk(8'h16, 32'h0, "R3 forced request removed");
    wr(8'h04, 32'h1);
    rdChk(8'h02, 32'd37, "R3 winner after removal");

    // re-mask
    wr(8'h1B, 32'h0000_0020);
    rdChk(8'h19, 32'hFFFF_FFFD, "R2 set port masks");
    wr(8'h04, 32'h1);
    pinChk(2'b10, "R2 masked source not delivered");

    // soft reset
    wr(8'h00, 32'h2);
    rdChk(8'h01, 32'h0, "R9 status low while resetting");
    pinChk(2'b00, "R9 lines low while resetting");
    wr(8'h12, 32'hFFFF_FFFF);
    repeat (8) @(negedge clk);
    rdChk(8'h01, 32'h1, "R9 status done");
    rdChk(8'h11, 32'hFFFF_FFFF, "R9 write ignored during reset");
    rdChk(8'h9F, 32'h0, "R9 line cleared");
    rdChk(8'h05, 32'hFF, "R9 threshold restored");
    pinChk(2'b00, "R9 all masked after reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule